// File: doc/BRIEF.md
# Fractional-N Divider Controller

This block divides an incoming high-speed clock by a sequence of integer moduli whose long-run average is a fractional number. The caller supplies a 7-bit integer part and an 18-bit fractional word. On every completed division the block emits a single-cycle pulse and loads the next modulus. A second-order cascade of two accumulators (MASH 1-1) produces that modulus, so its quantisation error is pushed towards high frequencies. The fractional word carries an implicit extra half LSB: the average modulus is integer + (fraction + 0.5) / 2^18. It never lands exactly on an integer unless integer-only mode is selected.

The counter is a three-state machine. PRIME is the reset state and lasts one cycle. It loads the first modulus and always moves to RUN. RUN counts down and moves to TERM when the count reaches one; otherwise it stays in RUN. TERM is the terminal-count cycle. It raises the output pulse, loads the next modulus, advances the modulator once, and always returns to RUN. The integer and fractional inputs are sampled only in PRIME and TERM.

Integer-only mode forces the modulator accumulators to zero. The modulus is then exactly the integer part, which gives lower jitter at the cost of frequency resolution.

Top module: `fnd_ctrl`

## Requirements
- R1: While reset is asserted, div_pulse_o is 0 and modulus_o is 0. After reset is released in integer-only mode with integer part N, the first pulse is high in the cycle that follows the N-th rising edge counted from the first edge with reset released.
- R2: div_pulse_o is high for exactly one cycle. The number of clock cycles from one pulse to the next equals the value modulus_o holds during that interval, and modulus_o still holds that value during the closing pulse cycle.
- R3: In integer-only mode (int_mode_i = 1), every loaded modulus equals the integer part exactly, whatever the fractional word is.
- R4: In fractional mode (int_mode_i = 0), every loaded modulus lies between integer part − 1 and integer part + 2 inclusive.
- R5: In fractional mode, 64 consecutive division periods add up to within 2 cycles of 64 × (integer + (2·fraction + 1) / 2^19).
- R6: In fractional mode with a fractional word of 0, the half-LSB offset still makes the modulus differ from the integer part at least once within the first 1200 divisions after reset.
- R7: A change of the integer part or the fractional word takes effect only at the next terminal count. The period in progress keeps its length, and modulus_o changes only in the cycle after a pulse (or after the PRIME cycle).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| int_part_i | input | 7 | Integer part of the modulus (3 or more) |
| frac_part_i | input | 18 | Fractional word; an implicit half LSB is added |
| int_mode_i | input | 1 | 1 = integer-only, modulator held at zero |
| div_pulse_o | output | 1 | One-cycle pulse at each terminal count |
| modulus_o | output | 8 | Modulus of the division now in progress |

## Verification
The assertions assume the integer part is at least 3. This keeps every modulus, even after a −1 step, at 2 or more, so that two pulses are never adjacent and the gap counter always sees a full period. The stimulus table and the directed tests only use integer parts from 3 to 127. They change inputs only at falling edges, either directly after a pulse or at a known offset inside a period. The range and exact-value properties compare against the input values of the loading cycle, so the inputs may change at any time without breaking them.

// File: rtl/fnd_pkg.sv
package fnd_pkg;
    localparam int INT_W  = 7;
    localparam int FRAC_W = 18;

    typedef enum logic [1:0] {
        ST_PRIME = 2'd0,
        ST_RUN   = 2'd1,
        ST_TERM  = 2'd2
    } fnd_state_e;

    typedef logic signed [2:0] fnd_step_t;
endpackage

// File: rtl/fnd_mash.sv
module fnd_mash
    import fnd_pkg::*;
#(
    parameter int FRAC_W = fnd_pkg::FRAC_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              advance_i,
    input  logic              bypass_i,
    input  logic [FRAC_W-1:0] frac_i,
    output fnd_step_t         step_o
);
    localparam int AW = FRAC_W + 1;

    logic [AW-1:0] acc1_q, acc2_q;
    logic          c2_q;
    logic [AW-1:0] f_word;
    logic [AW:0]   sum1, sum2;
    logic          c1, c2;

    always_comb begin
        f_word = {frac_i, 1'b1};
        sum1   = {1'b0, acc1_q} + {1'b0, f_word};
        sum2   = {1'b0, acc2_q} + {1'b0, sum1[AW-1:0]};
        c1     = sum1[AW];
        c2     = sum2[AW];
        if (bypass_i) begin
            step_o = '0;
        end else begin
            step_o = $signed({2'b00, c1}) + $signed({2'b00, c2})
                   - $signed({2'b00, c2_q});
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            acc1_q <= '0;
            acc2_q <= '0;
            c2_q   <= 1'b0;
        end else if (bypass_i) begin
            acc1_q <= '0;
            acc2_q <= '0;
            c2_q   <= 1'b0;
        end else if (advance_i) begin
            acc1_q <= sum1[AW-1:0];
            acc2_q <= sum2[AW-1:0];
            c2_q   <= c2;
        end
    end
endmodule

// File: rtl/fnd_modsum.sv
module fnd_modsum
    import fnd_pkg::*;
#(
    parameter int INT_W = fnd_pkg::INT_W,
    localparam int MOD_W = INT_W + 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [INT_W-1:0] int_part_i,
    input  fnd_step_t        step_i,
    output logic [MOD_W-1:0] mod_next_o,
    output logic [MOD_W-1:0] mod_q_o
);
    logic signed [MOD_W:0] wide;

    always_comb begin
        wide = $signed({2'b00, int_part_i})
             + $signed({{(MOD_W-2){step_i[2]}}, step_i});
        mod_next_o = wide[MOD_W-1:0];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            mod_q_o <= '0;
        end else if (load_i) begin
            mod_q_o <= mod_next_o;
        end
    end
endmodule

// File: rtl/fnd_divcnt.sv
module fnd_divcnt
    import fnd_pkg::*;
#(
    parameter int MOD_W = fnd_pkg::INT_W + 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [MOD_W-1:0] mod_i,
    output logic             load_o,
    output logic             pulse_o
);
    localparam logic [MOD_W-1:0] ONE = MOD_W'(1);

    fnd_state_e       state_q, state_d;
    logic [MOD_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_PRIME;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_PRIME: begin
                state_d = ST_RUN;
                cnt_d   = mod_i - ONE;
            end
            ST_RUN: begin
                if (cnt_q <= ONE) begin
                    state_d = ST_TERM;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q - ONE;
                end
            end
            ST_TERM: begin
                state_d = ST_RUN;
                cnt_d   = mod_i - ONE;
            end
            default: begin
                state_d = ST_PRIME;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        load_o  = 1'b0;
        pulse_o = 1'b0;
        unique case (state_q)
            ST_PRIME: load_o = 1'b1;
            ST_RUN:   ;
            ST_TERM: begin
                load_o  = 1'b1;
                pulse_o = 1'b1;
            end
            default:  ;
        endcase
    end
endmodule

// File: rtl/fnd_ctrl.sv
module fnd_ctrl
    import fnd_pkg::*;
#(
    parameter int INT_W  = fnd_pkg::INT_W,
    parameter int FRAC_W = fnd_pkg::FRAC_W,
    localparam int MOD_W = INT_W + 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [INT_W-1:0]  int_part_i,
    input  logic [FRAC_W-1:0] frac_part_i,
    input  logic              int_mode_i,
    output logic              div_pulse_o,
    output logic [MOD_W-1:0]  modulus_o
);
    logic             load;
    fnd_step_t        step;
    logic [MOD_W-1:0] mod_next;

    fnd_mash #(.FRAC_W(FRAC_W)) u_mash (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .advance_i (load),
        .bypass_i  (int_mode_i),
        .frac_i    (frac_part_i),
        .step_o    (step)
    );

    fnd_modsum #(.INT_W(INT_W)) u_sum (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (load),
        .int_part_i (int_part_i),
        .step_i     (step),
        .mod_next_o (mod_next),
        .mod_q_o    (modulus_o)
    );

    fnd_divcnt #(.MOD_W(MOD_W)) u_cnt (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .mod_i   (mod_next),
        .load_o  (load),
        .pulse_o (div_pulse_o)
    );
endmodule

// File: rtl/fnd_ctrl_chk.sv
module fnd_ctrl_chk #(
    parameter int INT_W = 7,
    localparam int MOD_W = INT_W + 1
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [INT_W-1:0] int_part_i,
    input logic             int_mode_i,
    input logic             div_pulse_o,
    input logic [MOD_W-1:0] modulus_o
);
    localparam logic [MOD_W-1:0] C1 = MOD_W'(1);
    localparam logic [MOD_W-1:0] C2 = MOD_W'(2);

    logic [MOD_W:0] gap_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            gap_q <= '0;
        end else if (div_pulse_o) begin
            gap_q <= {{MOD_W{1'b0}}, 1'b1};
        end else if (gap_q != '1) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // R2: pulse spacing matches the modulus shown
    a_r2_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
        div_pulse_o |-> (gap_q == {1'b0, modulus_o}));

    // R2: pulse lasts one cycle
    a_r2_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        div_pulse_o |=> !div_pulse_o);

    // R3: integer-only loads the integer part unchanged
    a_r3_int_exact: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(div_pulse_o) && $past(int_mode_i))
        |-> (modulus_o == {1'b0, $past(int_part_i)}));

    // R4: fractional step stays within -1..+2
    a_r4_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(div_pulse_o) && !$past(int_mode_i))
        |-> ((modulus_o + C1 >= {1'b0, $past(int_part_i)})
             && (modulus_o <= {1'b0, $past(int_part_i)} + C2)));

    // R7: modulus only changes right after a terminal count
    a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!$past(div_pulse_o) && ($past(modulus_o) != '0)) |-> $stable(modulus_o));
endmodule

bind fnd_ctrl fnd_ctrl_chk #(.INT_W(INT_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .int_part_i  (int_part_i),
    .int_mode_i  (int_mode_i),
    .div_pulse_o (div_pulse_o),
    .modulus_o   (modulus_o)
);

// File: tb/sim_fnd_ctrl.sv
`timescale 1ns/1ps
module sim_fnd_ctrl;
    localparam int NV = 7;
    localparam int K  = 64;
    localparam int unsigned V_INT  [NV] = '{3, 10, 10, 20, 127, 64, 3};
    localparam int unsigned V_FRAC [NV] = '{0, 0, 131072, 262143, 65536, 200000, 87381};
    localparam bit          V_MODE [NV] = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};

    logic        clk = 1'b0;
    logic        rst_n;
    logic [6:0]  int_part;
    logic [17:0] frac_part;
    logic        int_mode;
    logic        pulse;
    logic [7:0]  modulus;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    fnd_ctrl u0 (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .int_part_i  (int_part),
        .frac_part_i (frac_part),
        .int_mode_i  (int_mode),
        .div_pulse_o (pulse),
        .modulus_o   (modulus)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // counts falling edges up to and including the next pulse
    task automatic measure(output int gap, output int m);
        gap = 0;
        do begin
            @(negedge clk);
            gap++;
        end while (!pulse);
        m = int'(modulus);
    endtask

    initial begin
        #(4 * 190000);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        int gap, m;
        longint total, diff, f;
        bit seen;
        rst_n = 1'b0;
        int_part = 7'd3;
        frac_part = '0;
        int_mode = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset values
        check(pulse == 1'b0, "R1 pulse in reset", pulse, 0);
        check(modulus == 8'd0, "R1 modulus in reset", modulus, 0);
        rst_n = 1'b1;
        for (int k = 1; k <= 3; k++) begin
            @(posedge clk);
            @(negedge clk);
            check(pulse == (k == 3), "R1 first pulse timing", pulse, (k == 3));
        end

        // table of configurations
        for (int v = 0; v < NV; v++) begin
            int_part = V_INT[v][6:0];
            frac_part = V_FRAC[v][17:0];
            int_mode = V_MODE[v];
            measure(gap, m);
            measure(gap, m);
            total = 0;
            for (int p = 0; p < K; p++) begin
                measure(gap, m);
                total += gap;
                check(gap == m, "R2 period equals modulus", gap, m);
                if (V_MODE[v])
                    check(gap == int'(V_INT[v]), "R3 integer-only period", gap, V_INT[v]);
                else
                    check(gap >= int'(V_INT[v]) - 1 && gap <= int'(V_INT[v]) + 2,
                          "R4 period range", gap, V_INT[v]);
            end
            f = V_MODE[v] ? 0 : (2 * longint'(V_FRAC[v]) + 1);
            diff = total * 524288 - (longint'(K) * V_INT[v] * 524288 + K * f);
            if (V_MODE[v])
                check(diff == 0, "R3 integer-only total", total, longint'(K) * V_INT[v]);
            else
                check(diff <= 2 * 524288 && diff >= -2 * 524288, "R5 average modulus",
                      total, (longint'(K) * V_INT[v] * 524288 + K * f) / 524288);
        end

        // R7: change of integer part mid-period
        int_part = 7'd5;
        int_mode = 1'b1;
        frac_part = '0;
        measure(gap, m);
        measure(gap, m);
        @(negedge clk);
        @(negedge clk);
        int_part = 7'd9;
        gap = 2;
        while (!pulse) begin
            @(negedge clk);
            gap++;
        end
        check(gap == 5, "R7 period in progress kept", gap, 5);
        measure(gap, m);
        check(gap == 9, "R7 new value at next terminal count", gap, 9);
        check(m == 9, "R7 modulus output", m, 9);

        // R6: zero fractional word still dithers
        rst_n = 1'b0;
        int_part = 7'd3;
        frac_part = '0;
        int_mode = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        seen = 1'b0;
        for (int p = 0; p < 1200 && !seen; p++) begin
            measure(gap, m);
            if (m != 3) seen = 1'b1;
        end
        check(seen, "R6 half-LSB offset dithers", seen, 1);

        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule